// File: doc/BRIEF.md
# Exception Vector Fetch Sequencer

This block sits between a small processor core's exception logic and its memory read port, and fetches entries from an exception vector table. Each entry is a 32-bit word, and entry `n` is at byte offset `4*n` from the table base. When reset is released, the block first reads the word at the reset base and hands it to the core as the initial stack pointer. It then reads the next word and hands it to the core as the reset entry address. A strap input chooses the reset base: either zero or an alternate high address. The relocatable table base register is never used for this reset sequence.

After the reset sequence, the core can request an exception or interrupt by giving a vector number. Numbers 2 up to the last core-plus-interrupt entry are valid, which allows up to 256 interrupt entries after 16 core entries. The block reads only that one entry, at the current table base plus four times the number. Every fetched entry address must have bit 0 set. The block clears that bit before it loads the program counter. If bit 0 is clear, the block raises a one-cycle fault instead. Software writes the table base through a register port, and the low seven bits of the base are always zero.

The state machine has four states:
- `ST_BOOT_SP` reads the reset base. On `rd_ack` it moves to `ST_BOOT_PC`.
- `ST_BOOT_PC` reads the reset base plus 4. On `rd_ack` it moves to `ST_IDLE`.
- `ST_IDLE` waits for a request. An accepted request with a valid number moves it to `ST_FETCH`.
- `ST_FETCH` reads the latched entry address. On `rd_ack` it moves back to `ST_IDLE`.

The reset state is `ST_BOOT_SP`.

Top module: `vec_fetch_seq`

## Requirements
- R1: After reset is released, the first read is at the reset base. One cycle after that read's `rd_ack`, `sp_load` pulses for one cycle with `sp_value` equal to the returned word.
- R2: The second read after reset is at the reset base plus 4. Its word is treated as the reset entry address.
- R3: An entry word with bit 0 set produces a one-cycle `pc_load` pulse one cycle after `rd_ack`. `pc_value` is the word with bit 0 cleared.
- R4: An entry word with bit 0 clear produces a one-cycle `fault` pulse one cycle after `rd_ack`, and `pc_load` stays low.
- R5: The reset base is 0x00000000 when `boot_alt` is 0 and `ALT_BASE` (default 0x1FFF0000) when `boot_alt` is 1. It never depends on the table base register.
- R6: The table base register resets to 0. A write on `base_wr_en` stores `base_wr_data` with bits [6:0] forced to 0, and the new value appears on `base_q` one cycle later.
- R7: In `ST_IDLE`, a request with `exc_num` in [2, 271] causes exactly one read, at `base_q + 4*exc_num`. No stack pointer load follows.
- R8: A request with `exc_num` of 0, 1, or above 271 is ignored. No read is made and `busy` stays low.
- R9: `busy` is high from reset until the reset sequence ends, and from the accept cycle until the cycle after the final `rd_ack`. Requests made while `busy` is high are ignored.
- R10: Once raised, `rd_req` and `rd_addr` stay stable until `rd_ack`. Only one read is outstanding at a time.
- R11: At most one of `sp_load`, `pc_load` and `fault` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_alt | input | 1 | Strap: 1 selects the alternate high reset base |
| exc_req | input | 1 | Exception or interrupt request |
| exc_num | input | 9 | Vector number of the request |
| busy | output | 1 | A fetch sequence is in progress |
| base_wr_en | input | 1 | Table base register write strobe |
| base_wr_data | input | 32 | Table base write data |
| base_q | output | 32 | Current table base |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 32 | Read response word |
| sp_load | output | 1 | Stack pointer load strobe |
| sp_value | output | 32 | Initial stack pointer value |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 32 | Entry address with bit 0 cleared |
| fault | output | 1 | Fetched entry had bit 0 clear |

## Verification
The reset sequence is run with the strap at both values, so that a wrong base choice or a swapped word order shows up as a wrong address or value. Exception fetches are tried in several ways:
- Random vector numbers against randomly rewritten bases separate the offset arithmetic from the base masking.
- The directed numbers 2 and 271 probe both edges of the valid range.
- The numbers 0, 1, 272 and 511 probe the rejection path.

Words with bit 0 clear, placed at one chosen address, separate the fault path from the load path. A request held through an active fetch shows whether the busy hold-off drops it. The memory model answers after random delays, so any instability in `rd_req` or `rd_addr` while a read waits would show up as a wrong address.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

    typedef enum logic [1:0] {
        ST_BOOT_SP = 2'd0,
        ST_BOOT_PC = 2'd1,
        ST_IDLE    = 2'd2,
        ST_FETCH   = 2'd3
    } vfs_state_e;

    // Byte offset of the second reset word.
    localparam int unsigned RESET_PC_OFS = 4;
    // First vector number a non-reset request may use.
    localparam int unsigned FIRST_EXC_NUM = 2;

endpackage

// File: rtl/vfs_base_reg.sv
module vfs_base_reg #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned ALIGN_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] base_q
);
    localparam logic [WORD_W-1:0] KEEP_MASK = ~((WORD_W'(1) << ALIGN_BITS) - WORD_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= wr_data & KEEP_MASK;
        end
    end
endmodule

// File: rtl/vfs_addr_gen.sv
module vfs_addr_gen
    import vfs_pkg::*;
#(
    parameter int unsigned       WORD_W    = 32,
    parameter int unsigned       NUM_W     = 9,
    parameter int unsigned       LAST_NUM  = 271,
    parameter logic [WORD_W-1:0] ALT_BASE  = 32'h1FFF_0000
) (
    input  logic              boot_alt,
    input  logic [WORD_W-1:0] base_q,
    input  logic [NUM_W-1:0]  exc_num,
    output logic [WORD_W-1:0] boot_base,
    output logic [WORD_W-1:0] exc_addr,
    output logic              num_ok
);
    localparam logic [NUM_W-1:0] LO_NUM = NUM_W'(FIRST_EXC_NUM);
    localparam logic [NUM_W-1:0] HI_NUM = NUM_W'(LAST_NUM);

    logic [WORD_W-1:0] byte_ofs;

    always_comb begin
        boot_base = boot_alt ? ALT_BASE : '0;
        byte_ofs  = WORD_W'({exc_num, 2'b00});
        exc_addr  = base_q + byte_ofs;
        num_ok    = (exc_num >= LO_NUM) && (exc_num <= HI_NUM);
    end
endmodule

// File: rtl/vfs_entry_check.sv
module vfs_entry_check #(
    parameter int unsigned WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_clean,
    output logic              mode_ok
);
    always_comb begin
        mode_ok    = word_in[0];
        word_clean = {word_in[WORD_W-1:1], 1'b0};
    end
endmodule

// File: rtl/vfs_fsm.sv
module vfs_fsm
    import vfs_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic              num_ok,
    input  logic [WORD_W-1:0] exc_addr,
    input  logic [WORD_W-1:0] boot_base,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [WORD_W-1:0] word_clean,
    input  logic              mode_ok,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    output logic              busy,
    output logic              sp_load,
    output logic [WORD_W-1:0] sp_value,
    output logic              pc_load,
    output logic [WORD_W-1:0] pc_value,
    output logic              fault
);
    vfs_state_e        state_q, state_d;
    logic [WORD_W-1:0] addr_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && exc_req && num_ok;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT_SP: if (rd_ack) state_d = ST_BOOT_PC;
            ST_BOOT_PC: if (rd_ack) state_d = ST_IDLE;
            ST_IDLE:    if (accept) state_d = ST_FETCH;
            ST_FETCH:   if (rd_ack) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and latched entry address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT_SP;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) addr_q <= exc_addr;
        end
    end

    // Read port drive
    always_comb begin
        rd_req = (state_q != ST_IDLE);
        busy   = rd_req;
        unique case (state_q)
            ST_BOOT_SP: rd_addr = boot_base;
            ST_BOOT_PC: rd_addr = boot_base + WORD_W'(RESET_PC_OFS);
            default:    rd_addr = addr_q;
        endcase
    end

    // Registered result strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_load  <= 1'b0;
            pc_load  <= 1'b0;
            fault    <= 1'b0;
            sp_value <= '0;
            pc_value <= '0;
        end else begin
            sp_load <= 1'b0;
            pc_load <= 1'b0;
            fault   <= 1'b0;
            if (rd_ack) begin
                unique case (state_q)
                    ST_BOOT_SP: begin
                        sp_load  <= 1'b1;
                        sp_value <= rd_data;
                    end
                    ST_BOOT_PC, ST_FETCH: begin
                        if (mode_ok) begin
                            pc_load  <= 1'b1;
                            pc_value <= word_clean;
                        end else begin
                            fault <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/vec_fetch_seq.sv
module vec_fetch_seq
    import vfs_pkg::*;
#(
    parameter int unsigned       WORD_W     = 32,
    parameter int unsigned       CORE_ENT   = 16,
    parameter int unsigned       IRQ_ENT    = 256,
    parameter int unsigned       ALIGN_BITS = 7,
    parameter logic [WORD_W-1:0] ALT_BASE   = 32'h1FFF_0000,
    localparam int unsigned      NUM_ENT    = CORE_ENT + IRQ_ENT,
    localparam int unsigned      NUM_W      = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_alt,
    input  logic              exc_req,
    input  logic [NUM_W-1:0]  exc_num,
    output logic              busy,
    input  logic              base_wr_en,
    input  logic [WORD_W-1:0] base_wr_data,
    output logic [WORD_W-1:0] base_q,
    output logic              rd_req,
    output logic [WORD_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              sp_load,
    output logic [WORD_W-1:0] sp_value,
    output logic              pc_load,
    output logic [WORD_W-1:0] pc_value,
    output logic              fault
);
    logic [WORD_W-1:0] boot_base;
    logic [WORD_W-1:0] exc_addr;
    logic              num_ok;
    logic [WORD_W-1:0] word_clean;
    logic              mode_ok;

    vfs_base_reg #(.WORD_W(WORD_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (base_wr_en),
        .wr_data(base_wr_data),
        .base_q (base_q)
    );

    vfs_addr_gen #(
        .WORD_W  (WORD_W),
        .NUM_W   (NUM_W),
        .LAST_NUM(NUM_ENT - 1),
        .ALT_BASE(ALT_BASE)
    ) u_addr (
        .boot_alt (boot_alt),
        .base_q   (base_q),
        .exc_num  (exc_num),
        .boot_base(boot_base),
        .exc_addr (exc_addr),
        .num_ok   (num_ok)
    );

    vfs_entry_check #(.WORD_W(WORD_W)) u_chk_entry (
        .word_in   (rd_data),
        .word_clean(word_clean),
        .mode_ok   (mode_ok)
    );

    vfs_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_req   (exc_req),
        .num_ok    (num_ok),
        .exc_addr  (exc_addr),
        .boot_base (boot_base),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .word_clean(word_clean),
        .mode_ok   (mode_ok),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .sp_load   (sp_load),
        .sp_value  (sp_value),
        .pc_load   (pc_load),
        .pc_value  (pc_value),
        .fault     (fault)
    );
endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned ALIGN_BITS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              rd_req,
    input logic [WORD_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic [WORD_W-1:0] base_q,
    input logic              sp_load,
    input logic              pc_load,
    input logic [WORD_W-1:0] pc_value,
    input logic              fault
);
    a_r1_sp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |-> $past(rd_ack));

    a_r3_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (pc_value[0] == 1'b0));

    a_r4_fault_no_pc: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !pc_load);

    a_r6_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[ALIGN_BITS-1:0] == '0);

    a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (pc_load || fault));

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sp_load, pc_load, fault}));
endmodule

bind vec_fetch_seq vfs_checker #(.WORD_W(WORD_W), .ALIGN_BITS(ALIGN_BITS)) u_vfs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .base_q  (base_q),
    .sp_load (sp_load),
    .pc_load (pc_load),
    .pc_value(pc_value),
    .fault   (fault)
);

// File: tb/vec_fetch_seq_tb.sv
module vec_fetch_seq_tb;
    localparam logic [31:0] ALT = 32'h1FFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_alt = 1'b0;
    logic        exc_req = 1'b0;
    logic [8:0]  exc_num = '0;
    logic        busy;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic [31:0] base_q;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        sp_load, pc_load, fault;
    logic [31:0] sp_value, pc_value;

    always #5 clk = ~clk;

    vec_fetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .boot_alt(boot_alt), .exc_req(exc_req),
        .exc_num(exc_num), .busy(busy), .base_wr_en(base_wr_en),
        .base_wr_data(base_wr_data), .base_q(base_q), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .sp_load(sp_load), .sp_value(sp_value), .pc_load(pc_load),
        .pc_value(pc_value), .fault(fault)
    );

    int          checks = 0;
    int          fails = 0;
    logic [31:0] bad_addr = 32'hFFFF_FFFF;
    logic [31:0] base_model = '0;
    int          rd_cnt, sp_cnt, pc_cnt, flt_cnt;
    logic [31:0] addr_log [0:3];
    logic [31:0] last_sp, last_pc;
    int          lat = 0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        w = (a * 32'h9E37_79B1) ^ 32'h2000_1000;
        if (a == bad_addr) return w & ~32'h1;
        return w | 32'h1;
    endfunction

    function automatic logic [31:0] exp_entry(input logic [31:0] b, input int n);
        return b + 32'(4 * n);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        rd_cnt = 0; sp_cnt = 0; pc_cnt = 0; flt_cnt = 0;
    endtask

    // Memory responder with random latency
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rd_ack = 1'b0;
            end else if (rd_ack) begin
                rd_ack = 1'b0;
                lat = int'($urandom % 3);
            end else if (rd_req) begin
                if (lat == 0) begin
                    rd_ack  = 1'b1;
                    rd_data = mem_word(rd_addr);
                    if (rd_cnt < 4) addr_log[rd_cnt] = rd_addr;
                    rd_cnt++;
                end else begin
                    lat--;
                end
            end
        end
    end

    // Output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sp_load) begin sp_cnt++; last_sp = sp_value; end
                if (pc_load) begin pc_cnt++; last_pc = pc_value; end
                if (fault) flt_cnt++;
            end
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic do_boot(input logic alt);
        logic [31:0] b;
        @(negedge clk);
        rst_n = 1'b0; boot_alt = alt;
        repeat (3) @(negedge clk);
        chk(!sp_load && !pc_load && !fault, "R11 reset strobes", {29'd0, sp_load, pc_load, fault}, 32'd0);
        chk(base_q == 32'd0, "R6 reset base", base_q, 32'd0);
        base_model = '0;
        clear_logs();
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy during boot", {31'd0, busy}, 32'd1);
        wait_idle();
        b = alt ? ALT : 32'd0;
        chk(rd_cnt == 2, "R2 boot read count", rd_cnt, 2);
        chk(addr_log[0] == b, "R1 R5 first boot addr", addr_log[0], b);
        chk(addr_log[1] == b + 32'd4, "R2 second boot addr", addr_log[1], b + 32'd4);
        chk(sp_cnt == 1 && last_sp == mem_word(b), "R1 stack value", last_sp, mem_word(b));
        if (bad_addr == b + 32'd4) begin
            chk(flt_cnt == 1 && pc_cnt == 0, "R4 boot fault", flt_cnt, 1);
        end else begin
            chk(pc_cnt == 1 && last_pc == (mem_word(b + 32'd4) & ~32'h1), "R3 boot entry",
                last_pc, mem_word(b + 32'd4) & ~32'h1);
        end
    endtask

    task automatic wr_base(input logic [31:0] d);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = d;
        @(negedge clk);
        base_wr_en = 1'b0;
        base_model = d & ~32'h7F;
        chk(base_q == base_model, "R6 base write", base_q, base_model);
    endtask

    task automatic do_exc(input int n, input bit valid);
        logic [31:0] a;
        clear_logs();
        @(negedge clk);
        exc_req = 1'b1; exc_num = 9'(n);
        @(negedge clk);
        exc_req = 1'b0;
        if (valid) begin
            wait_idle();
            a = exp_entry(base_model, n);
            chk(rd_cnt == 1 && addr_log[0] == a, "R7 entry addr", addr_log[0], a);
            chk(sp_cnt == 0, "R7 no stack load", sp_cnt, 0);
            if (a == bad_addr)
                chk(flt_cnt == 1 && pc_cnt == 0, "R4 entry fault", pc_cnt, 0);
            else
                chk(pc_cnt == 1 && last_pc == (mem_word(a) & ~32'h1), "R3 entry value",
                    last_pc, mem_word(a) & ~32'h1);
        end else begin
            repeat (4) @(negedge clk);
            chk(rd_cnt == 0 && !busy, "R8 ignored number", rd_cnt, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_boot(1'b0);
        do_boot(1'b1);
        bad_addr = ALT + 32'd4;
        do_boot(1'b1);                       // R4 on the reset entry
        bad_addr = 32'hFFFF_FFFF;
        do_boot(1'b0);

        wr_base(32'h2000_00FF);              // R6 masking
        do_exc(2, 1'b1);                     // lowest valid number
        do_exc(271, 1'b1);                   // highest valid number
        do_exc(0, 1'b0);
        do_exc(1, 1'b0);
        do_exc(272, 1'b0);
        do_exc(511, 1'b0);

        for (int k = 0; k < 40; k++) begin
            if (($urandom % 4) == 0) wr_base($urandom);
            do_exc(2 + int'($urandom % 270), 1'b1);
        end

        bad_addr = exp_entry(base_model, 37);
        do_exc(37, 1'b1);                    // R4 on an exception entry
        bad_addr = 32'hFFFF_FFFF;

        // R9: request held through an active fetch is dropped
        clear_logs();
        @(negedge clk);
        exc_req = 1'b1; exc_num = 9'd5;
        @(negedge clk);
        exc_num = 9'd9;
        for (int i = 0; i < 60; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        exc_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(rd_cnt == 1 && addr_log[0] == exp_entry(base_model, 5), "R9 held request dropped",
            addr_log[0], exp_entry(base_model, 5));

        // R5: reset after relocation fetches from the reset base
        wr_base(32'h4000_0000);
        do_boot(1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule